// File: doc/BRIEF.md
# Quad Two-Rank Converter Code Register Interface

This block is the digital host interface of a four-channel, 8-bit voltage-output converter. A host drives an 8-bit data bus, a 2-bit channel select, an active-low write strobe and an active-low load strobe that all four channels share. Each channel holds its value in two ranks. The front rank (staging register) is loaded through the write strobe. The back rank (output register) drives the channel's code. Both strobes act as level-sensitive latches. While the write strobe is low, the selected staging register follows the bus. While the load strobe is low, every output register follows its own staging register.

The strobes arrive with no fixed relation to the block clock. They therefore pass through a synchronizer together with the bus and the select lines, and the two register ranks are then updated in the clock domain. A code D on an output stands for the fraction D/256 of full scale, from 0 up to 255/256. The block also watches one timing rule. If the load strobe was already low when a write ended, it must stay low for at least `HOLD_CYCLES` clock cycles after that. If it rises sooner, a sticky flag is raised.

Top module: `qdac_if_top`

## Requirements
- R1: A synchronous active-high reset sets all staging and output registers to 0x00 and clears `hold_violation`.
- R2: The channel select picks the staging register: 0 selects channel A, 1 selects B, 2 selects C and 3 selects D. Channel n's code is driven on `dac_code[8n+7:8n]`.
- R3: While `write_n` is low, the selected staging register follows `data_in`. The other three staging registers keep their values.
- R4: When `write_n` rises, the selected staging register keeps the last value it saw with the strobe low. Later changes of `data_in` leave it unchanged while `write_n` stays high.
- R5: While `load_n` is low, all four output registers follow their own staging registers.
- R6: When `load_n` rises, all four output registers freeze together. Writes made afterwards do not reach `dac_code` until the next time `load_n` goes low.
- R7: While both strobes are low, the selected channel's code tracks `data_in`. A change on the pins shows on `dac_code` after exactly three rising clock edges: two synchronizer stages and one register.
- R8: While both strobes are high, changes on `data_in` and `addr_in` alter no code.
- R9: `hold_violation` is set when `load_n` was low at a rise of `write_n` and then rises fewer than `HOLD_CYCLES` cycles later. A gap of `HOLD_CYCLES` or more does not set it. A `load_n` pulse that starts after `write_n` has risen does not set it.
- R10: Once set, `hold_violation` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; it also samples the strobes |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 8 | Host data bus |
| addr_in | input | 2 | Channel select (0=A, 1=B, 2=C, 3=D) |
| write_n | input | 1 | Write strobe, active low, level sensitive |
| load_n | input | 1 | Shared load strobe, active low, level sensitive |
| dac_code | output | 32 | Four output codes; channel n in bits 8n+7:8n |
| hold_violation | output | 1 | Sticky flag for a load-hold violation |

## Verification
Some properties are checked by assertions on every cycle. An unselected or idle staging register never changes. An output register never moves while the load strobe is high. After a cycle with load active and write idle, the outputs equal the staging registers. The violation flag never falls without reset, and the hold counter never passes its limit. Other behaviour can only be shown by the bench scenarios. These are the three-edge latency of flow-through, the value kept when the write strobe rises while the bus then changes, the address decode swept over every channel and every code, and the exact gap length at which the hold rule starts or stops flagging.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    localparam int NUM_CH = 4;
    localparam int CODE_W = 8;
    localparam int SEL_W  = $clog2(NUM_CH);

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SEL_W-1:0]  sel_t;
    typedef logic [NUM_CH-1:0] ch_mask_t;

    // Host request after polarity conversion: strobe fields are 1 when active.
    typedef struct packed {
        logic  wr_low;
        logic  ld_low;
        sel_t  sel;
        code_t data;
    } host_req_t;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_WRITE = 2'b01,
        MODE_LOAD  = 2'b10,
        MODE_FLOW  = 2'b11
    } strobe_mode_e;

    function automatic strobe_mode_e decode_mode(input logic wr_low, input logic ld_low);
        strobe_mode_e m;
        case ({ld_low, wr_low})
            2'b01:   m = MODE_WRITE;
            2'b10:   m = MODE_LOAD;
            2'b11:   m = MODE_FLOW;
            default: m = MODE_IDLE;
        endcase
        return m;
    endfunction

    function automatic ch_mask_t sel_onehot(input sel_t s);
        ch_mask_t r;
        r = '0;
        r[s] = 1'b1;
        return r;
    endfunction

    function automatic logic mode_writes(input strobe_mode_e m);
        return (m == MODE_WRITE) || (m == MODE_FLOW);
    endfunction

    function automatic logic mode_loads(input strobe_mode_e m);
        return (m == MODE_LOAD) || (m == MODE_FLOW);
    endfunction

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/qdac_input_bank.sv
module qdac_input_bank
    import qdac_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  host_req_t              req,
    output logic [NUM_CH-1:0][CODE_W-1:0] stage_q,
    output logic [NUM_CH-1:0][CODE_W-1:0] stage_next
);

    strobe_mode_e mode;
    ch_mask_t     hit;
    logic         wr_en;

    assign mode  = decode_mode(req.wr_low, req.ld_low);
    assign wr_en = mode_writes(mode);
    assign hit   = sel_onehot(req.sel);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        always_comb begin
            if (wr_en && hit[ch]) begin
                stage_next[ch] = req.data;
            end else begin
                stage_next[ch] = stage_q[ch];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[ch] <= '0;
            end else begin
                stage_q[ch] <= stage_next[ch];
            end
        end

        AST_IDLE_CHANNEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
            !(req.wr_low && (req.sel == sel_t'(ch))) |=> $stable(stage_q[ch])); // R3
    end

endmodule

// File: rtl/qdac_load_bank.sv
module qdac_load_bank
    import qdac_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ld_low,
    input  logic [NUM_CH-1:0][CODE_W-1:0] stage_next,
    output logic [NUM_CH-1:0][CODE_W-1:0] out_q
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                out_q[ch] <= '0;
            end else if (ld_low) begin
                out_q[ch] <= stage_next[ch];
            end
        end
    end

    AST_DAC_LATCHED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !ld_low |=> $stable(out_q)); // R6

endmodule

// File: rtl/qdac_hold_check.sv
module qdac_hold_check #(
    parameter int HOLD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_low,
    input  logic ld_low,
    output logic hold_violation
);

    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_CYCLES);

    logic             wr_prev, ld_prev;
    logic             armed;
    logic [CNT_W-1:0] gap;
    logic             wr_rise, ld_rise, overlap;

    assign wr_rise = wr_prev && !wr_low;
    assign ld_rise = ld_prev && !ld_low;
    assign overlap = wr_rise && ld_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_prev        <= 1'b0;
            ld_prev        <= 1'b0;
            armed          <= 1'b0;
            gap            <= '0;
            hold_violation <= 1'b0;
        end else begin
            wr_prev <= wr_low;
            ld_prev <= ld_low;
            if (overlap) begin
                if (ld_rise) begin
                    hold_violation <= 1'b1;
                    armed          <= 1'b0;
                end else begin
                    armed <= 1'b1;
                    gap   <= CNT_W'(1);
                end
            end else if (armed) begin
                if (ld_rise) begin
                    if (gap < LIMIT) begin
                        hold_violation <= 1'b1;
                    end
                    armed <= 1'b0;
                end else if (gap < LIMIT) begin
                    gap <= gap + CNT_W'(1);
                end
            end
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        hold_violation |=> hold_violation); // R10

    AST_GAP_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        gap <= LIMIT); // R9

endmodule

// File: rtl/qdac_if_top.sv
module qdac_if_top
    import qdac_pkg::*;
#(
    parameter int HOLD_CYCLES = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [CODE_W-1:0]        data_in,
    input  logic [SEL_W-1:0]         addr_in,
    input  logic                     write_n,
    input  logic                     load_n,
    output logic [NUM_CH*CODE_W-1:0] dac_code,
    output logic                     hold_violation
);

    localparam int REQ_W = $bits(host_req_t);

    host_req_t        req_raw, req_s;
    logic [REQ_W-1:0] req_q;
    logic [NUM_CH-1:0][CODE_W-1:0] stage_q, stage_next, out_q;

    always_comb begin
        req_raw.wr_low = ~write_n;
        req_raw.ld_low = ~load_n;
        req_raw.sel    = addr_in;
        req_raw.data   = data_in;
    end

    qdac_sync #(.W(REQ_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (req_raw),
        .q   (req_q)
    );

    assign req_s = host_req_t'(req_q);

    qdac_input_bank in_bank_i (
        .clk        (clk),
        .rst        (rst),
        .req        (req_s),
        .stage_q    (stage_q),
        .stage_next (stage_next)
    );

    qdac_load_bank out_bank_i (
        .clk        (clk),
        .rst        (rst),
        .ld_low     (req_s.ld_low),
        .stage_next (stage_next),
        .out_q      (out_q)
    );

    qdac_hold_check #(.HOLD_CYCLES(HOLD_CYCLES)) hold_i (
        .clk            (clk),
        .rst            (rst),
        .wr_low         (req_s.wr_low),
        .ld_low         (req_s.ld_low),
        .hold_violation (hold_violation)
    );

    assign dac_code = out_q;

    AST_DAC_MATCHES_INPUT: assert property (@(posedge clk) disable iff (rst)
        ($past(req_s.ld_low) && !$past(req_s.wr_low)) |-> (out_q == stage_q)); // R5

endmodule

// File: tb/qdac_if_top_tb_top.sv
module qdac_if_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  data_in = 8'h00;
    logic [1:0]  addr_in = 2'd0;
    logic        write_n = 1'b1;
    logic        load_n  = 1'b1;
    logic [31:0] dac_code;
    logic        hold_violation;

    int errors = 0;
    int checks = 0;
    logic [7:0] in_m  [4];
    logic [7:0] dac_m [4];
    bit ld_low_m = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qdac_if_top #(.HOLD_CYCLES(HOLD)) dut_i (
        .clk            (clk),
        .rst            (rst),
        .data_in        (data_in),
        .addr_in        (addr_in),
        .write_n        (write_n),
        .load_n         (load_n),
        .dac_code       (dac_code),
        .hold_violation (hold_violation)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_codes(input string req);
        for (int ch = 0; ch < 4; ch++) begin
            checks++;
            if (dac_code[ch*8 +: 8] !== dac_m[ch]) begin
                errors++;
                $display("FAIL %s ch%0d actual=%02h expected=%02h", req, ch,
                         dac_code[ch*8 +: 8], dac_m[ch]);
            end
        end
    endtask

    task automatic check_flag(input logic exp, input string req);
        checks++;
        if (hold_violation !== exp) begin
            errors++;
            $display("FAIL %s hold_violation actual=%0b expected=%0b", req, hold_violation, exp);
        end
    endtask

    task automatic write_ch(input int ch, input logic [7:0] v);
        addr_in = ch[1:0];
        data_in = v;
        write_n = 1'b0;
        tick(2);
        write_n = 1'b1;
        tick(1);
        data_in = ~v;
        in_m[ch] = v;
        if (ld_low_m) dac_m[ch] = v;
    endtask

    task automatic load_pulse();
        load_n = 1'b0;
        tick(2);
        load_n = 1'b1;
        tick(1);
        for (int ch = 0; ch < 4; ch++) dac_m[ch] = in_m[ch];
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        for (int ch = 0; ch < 4; ch++) begin
            in_m[ch]  = 8'h00;
            dac_m[ch] = 8'h00;
        end
    endtask

    // Overlapped write then load released 'gap' cycles after the write ends.
    task automatic hold_case(input int gap);
        load_n = 1'b0;
        ld_low_m = 1'b1;
        tick(2);
        write_ch(3, 8'hC3);
        tick(gap - 1);
        load_n = 1'b1;
        ld_low_m = 1'b0;
        tick(6);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        tick(1);
        do_reset();
        tick(4);
        check_codes("R1 after reset");
        check_flag(1'b0, "R1 after reset");

        // R2 R4 R6 R8: sweep every code on every channel, load separately.
        for (int ch = 0; ch < 4; ch++) begin
            for (int v = 0; v < 256; v++) begin
                write_ch(ch, v[7:0]);
                tick(4);
                check_codes("R6 R4 output frozen while load high");
                load_pulse();
                tick(4);
                check_codes("R2 R5 decode and load");
            end
        end
        check_flag(1'b0, "R9 no overlap in sweep");

        // R8: both strobes high, bus and select wander.
        for (int k = 0; k < 8; k++) begin
            addr_in = k[1:0];
            data_in = 8'(k * 29 + 3);
            tick(2);
        end
        tick(4);
        check_codes("R8 idle strobes change nothing");

        // R7: both low, flow-through with exact latency.
        load_n = 1'b0;
        ld_low_m = 1'b1;
        addr_in = 2'd2;
        data_in = in_m[2];
        write_n = 1'b0;
        tick(4);
        for (int k = 0; k < 6; k++) begin
            data_in = 8'(8'h11 * (k + 1));
            tick(2);
            check_codes("R7 two edges after change still old");
            in_m[2] = 8'(8'h11 * (k + 1));
            dac_m[2] = in_m[2];
            tick(1);
            check_codes("R7 third edge shows new code");
        end

        // R4: capture on write rise, bus then changes.
        data_in = 8'h5A;
        tick(3);
        write_n = 1'b1;
        tick(1);
        data_in = 8'hFF;
        in_m[2] = 8'h5A;
        dac_m[2] = 8'h5A;
        tick(5);
        check_codes("R4 captured value held after write rise");

        // R3 R5: load held low, other channel written, all follow.
        write_ch(1, 8'h33);
        tick(4);
        check_codes("R3 R5 load low follows staging");
        write_ch(0, 8'hE7);
        tick(4);
        check_codes("R3 R5 second channel");
        load_n = 1'b1;
        ld_low_m = 1'b0;
        tick(6);
        check_flag(1'b0, "R9 long gap no flag");

        // R6: after latch, writes stay hidden until next load.
        write_ch(0, 8'h08);
        write_ch(3, 8'h90);
        tick(4);
        check_codes("R6 latched after load rise");
        load_pulse();
        tick(4);
        check_codes("R6 next load shows new writes");

        // R9: gap exactly HOLD -> no flag.
        hold_case(HOLD);
        check_flag(1'b0, "R9 gap equal to hold");
        hold_case(HOLD + 2);
        check_flag(1'b0, "R9 gap above hold");
        // R9: non-overlapped short load pulse -> no flag.
        write_ch(1, 8'h44);
        load_pulse();
        tick(4);
        check_flag(1'b0, "R9 load after write no flag");
        check_codes("R5 short pulse loads");
        // R9: gap one short -> flag.
        hold_case(HOLD - 1);
        check_flag(1'b1, "R9 gap one below hold");

        // R10: sticky through clean traffic.
        write_ch(2, 8'h21);
        load_pulse();
        tick(8);
        check_flag(1'b1, "R10 flag stays set");

        // R9 second short gap after reset.
        do_reset();
        tick(4);
        check_flag(1'b0, "R1 R10 reset clears flag");
        check_codes("R1 reset clears codes");
        hold_case(2);
        check_flag(1'b1, "R9 gap of two");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule